// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a four-wire test access port for a chip's boundary scan. A 16-state controller steps on the rising edge of the test clock, following the test mode select line. It keeps a 4-bit instruction register, and the current instruction picks which data register sits between the serial input and the serial output. Three data registers are built in:

- a one-stage bypass cell;
- a 32-bit identification register;
- a one-stage core-reset register.

The pin scan chain lives outside the block. The block drives it with the serial input and with capture, shift and update strobes. It takes the chain's serial output back into its own output multiplexer. A mode line tells the pad logic when the latched chain values must drive the pins.

Board test software uses the block as follows. It preloads safe pin values with the sample instruction, then switches to the external-test instruction to drive those values onto the board nets. It can hold the core in reset by shifting a one into the reset register. The identification code is the first thing a data scan returns after reset.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the controller goes to Test-Logic-Reset and the current instruction becomes IDCODE (0x1). After that edge `tdo_oe`, `core_rst_req` and `bs_drive_pins` are 0.
- R2: The controller follows the standard 16-state transition graph. Five rising edges with `tms` high, starting from any state, reach Test-Logic-Reset, and this restores IDCODE as the instruction.
- R3: In Capture-IR the instruction shifter loads 4'b0001. Shift-IR moves bits in from `tdi` and out on `tdo`, least significant bit first. The shifted value becomes the current instruction only on leaving Update-IR.
- R4: Under IDCODE (0x1), Capture-DR loads 0x0940303F: version 0x0 in bits 31:28, part 0x9403 in bits 27:12, maker 0x01F in bits 11:1, and bit 0 set. The value shifts out least significant bit first.
- R5: Under BYPASS (0xF) the path is one cell. Capture-DR loads 0 into it, so a scan returns 0 first and then the input bits delayed by one.
- R6: Any opcode other than 0x0, 0x1, 0x2, 0xC and 0xF behaves exactly as BYPASS.
- R7: Under the reset opcode 0xC, a one-cell register is shifted in Shift-DR only, with no capture and no update latch. `core_rst_req` equals its content and rises on the same edge that shifts in a 1. Changing the instruction neither clears the register nor resets the controller.
- R8: EXTEST (0x0) and SAMPLE/PRELOAD (0x2) select the external chain and raise `bs_sel`. `bs_capture`, `bs_shift` and `bs_update` are high in Capture-DR, Shift-DR and Update-DR respectively. `bs_so` is routed to `tdo`, and `bs_si` carries `tdi`.
- R9: `bs_drive_pins` is 1 exactly while EXTEST is the current instruction, from the edge that leaves Update-IR. It stays 0 under SAMPLE/PRELOAD.
- R10: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on the rising test clock edge |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| core_rst_req | output | 1 | Core reset request, straight from the reset register |
| bs_sel | output | 1 | External chain is the selected data path |
| bs_capture | output | 1 | Chain capture strobe |
| bs_shift | output | 1 | Chain shift strobe |
| bs_update | output | 1 | Chain update strobe |
| bs_drive_pins | output | 1 | Latched chain values drive the pins |
| bs_si | output | 1 | Serial data into the chain |
| bs_so | input | 1 | Serial data back from the chain |

## Verification
The final bit of every scan leaves the shift state and moves the last data bit on the same rising edge. For the reset register, this also means the request rises on the very edge where the controller heads to Exit1-DR. The bench makes each scan's last shift step carry `tms` high, so the transition and the shift always coincide. It then judges the outcome from the full returned bit vector, the chain latch contents and `core_rst_req` read on the next falling edge. A five-high escape is issued from inside Shift-DR, so that leaving mid-scan and restoring IDCODE occur together; a following scan must return the identification code.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
// Shared types for the test access port.
// Assumes: a 4-bit state encoding is enough for the 16 controller states.
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_CHAIN, PATH_ID, PATH_RST, PATH_BYP
    } dr_path_t;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
// Controller state machine of the test access port.
// Steps on every rising tck edge from tms; trst_n is a synchronous,
// active-low reset into the reset state.
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state function of the standard transition graph.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // Checker counter: consecutive tms-high edges since reset, saturating.
    logic [2:0] high_run;
    always_ff @(posedge tck) begin
        if (!trst_n || !tms)   high_run <= 3'd0;
        else if (high_run != 3'd7) high_run <= high_run + 3'd1;
    end

    // R2
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (high_run >= 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
// Instruction shifter, current instruction and path decode.
// Assumes the state input comes from tap_fsm; the current instruction
// changes only on the edge leaving Update-IR or in the reset state.
module tap_ir
    import scan_tap_pkg::*;
#(
    parameter int              IR_W        = 4,
    parameter logic [IR_W-1:0] OP_EXTEST   = 4'h0,
    parameter logic [IR_W-1:0] OP_IDCODE   = 4'h1,
    parameter logic [IR_W-1:0] OP_SAMPLE   = 4'h2,
    parameter logic [IR_W-1:0] OP_CORERST  = 4'hC,
    parameter logic [IR_W-1:0] OP_BYPASS   = 4'hF,
    parameter logic [IR_W-1:0] CAPTURE_PAT = 4'b0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    output logic       ir_lsb,
    output dr_path_t   path,
    output logic       extest_on
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_cur;

    // Shift stage: fixed pattern on capture, LSB-first shift from tdi.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sr <= CAPTURE_PAT;
        else if (state == ST_CAP_IR) ir_sr <= CAPTURE_PAT;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Current instruction: IDCODE in reset, shifted value on Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) ir_cur <= OP_IDCODE;
        else if (state == ST_UPD_IR)      ir_cur <= ir_sr;
    end

    // Path decode; any opcode not listed selects the bypass cell.
    always_comb begin
        if (ir_cur == OP_EXTEST || ir_cur == OP_SAMPLE) path = PATH_CHAIN;
        else if (ir_cur == OP_IDCODE)                   path = PATH_ID;
        else if (ir_cur == OP_CORERST)                  path = PATH_RST;
        else                                            path = PATH_BYP;
    end

    // Pin drive mode and serial output bit.
    assign extest_on = (ir_cur == OP_EXTEST);
    assign ir_lsb    = ir_sr[0];

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == CAPTURE_PAT));

    // R3
    ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_cur));

    // R9
    bypass_unused_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (path == PATH_BYP) |-> !extest_on && ir_cur != OP_IDCODE);

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
// Built-in data registers (bypass, identification, core reset) and the
// data-path output select, including the external chain return.
// Assumes the path input is stable across a scan.
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h0940_303F
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  dr_path_t   path,
    input  logic       chain_so,
    output logic       dr_lsb,
    output logic       rst_req
);

    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            rst_q;

    // Bypass cell: cleared on capture, shifted from tdi.
    always_ff @(posedge tck) begin
        if (!trst_n) byp_q <= 1'b0;
        else if (path == PATH_BYP) begin
            if (state == ST_CAP_DR)     byp_q <= 1'b0;
            else if (state == ST_SH_DR) byp_q <= tdi;
        end
    end

    // Identification shifter: loads the code on capture, LSB-first shift.
    always_ff @(posedge tck) begin
        if (!trst_n) id_sr <= ID_VAL;
        else if (path == PATH_ID) begin
            if (state == ST_CAP_DR)     id_sr <= ID_VAL;
            else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    // Core-reset cell: shift only, no capture, no update latch.
    always_ff @(posedge tck) begin
        if (!trst_n)                                  rst_q <= 1'b0;
        else if (path == PATH_RST && state == ST_SH_DR) rst_q <= tdi;
    end

    // Serial output of the selected data path.
    always_comb begin
        unique case (path)
            PATH_CHAIN: dr_lsb = chain_so;
            PATH_ID:    dr_lsb = id_sr[0];
            PATH_RST:   dr_lsb = rst_q;
            default:    dr_lsb = byp_q;
        endcase
    end

    assign rst_req = rst_q;

    // R5
    bypass_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && path == PATH_BYP) |=> (byp_q == 1'b0));

    // R7
    rst_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_SH_DR && path == PATH_RST) |=> $stable(rst_req));

    // R4
    id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && path == PATH_ID) |=> (dr_lsb == ID_VAL[0]));

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
// Top of the boundary-scan test access port: controller, instruction
// register, built-in data registers, falling-edge output stage and the
// strobes for an external pin chain. Assumes the chain acts on rising
// tck edges while its strobes are high.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [15:0] ID_PART    = 16'h9403,
    parameter logic [10:0] ID_MAKER   = 11'h01F
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic core_rst_req,
    output logic bs_sel,
    output logic bs_capture,
    output logic bs_shift,
    output logic bs_update,
    output logic bs_drive_pins,
    output logic bs_si,
    input  logic bs_so
);

    localparam int              IR_W   = 4;
    localparam int              ID_W   = $bits(ID_VERSION) + $bits(ID_PART) + $bits(ID_MAKER) + 1;
    localparam logic [ID_W-1:0] ID_VAL = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    tap_state_t state;
    dr_path_t   path;
    logic       ir_lsb, dr_lsb, extest_on;
    logic       tdo_q, oe_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir #(.IR_W(IR_W)) u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .ir_lsb    (ir_lsb),
        .path      (path),
        .extest_on (extest_on)
    );

    tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state    (state),
        .path     (path),
        .chain_so (bs_so),
        .dr_lsb   (dr_lsb),
        .rst_req  (core_rst_req)
    );

    // Output stage on the falling edge: bit and enable for the shift states.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo_q <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
        end
    end

    // External chain controls.
    assign bs_sel        = (path == PATH_CHAIN);
    assign bs_capture    = bs_sel && (state == ST_CAP_DR);
    assign bs_shift      = bs_sel && (state == ST_SH_DR);
    assign bs_update     = bs_sel && (state == ST_UPD_DR);
    assign bs_drive_pins = extest_on;
    assign bs_si         = tdi;
    assign tdo           = tdo_q;
    assign tdo_oe        = oe_q;

    // R10
    oe_shift_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

    // R8
    strobe_exclusive_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bs_capture, bs_shift, bs_update}));

    // R9
    drive_needs_chain_chk: assert property (@(posedge tck) disable iff (!trst_n)
        bs_drive_pins |-> bs_sel);

endmodule

// File: tb/scan_tap_tb.sv
`timescale 1ns/1ps
module scan_tap_tb;

    logic tck = 1'b0;
    logic trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, core_rst_req, bs_sel, bs_capture, bs_shift, bs_update;
    logic bs_drive_pins, bs_si, bs_so;

    int checks = 0, fails = 0;
    logic last_oe;

    always #10 tck = ~tck;

    scan_tap u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_rst_req(core_rst_req), .bs_sel(bs_sel), .bs_capture(bs_capture),
        .bs_shift(bs_shift), .bs_update(bs_update), .bs_drive_pins(bs_drive_pins),
        .bs_si(bs_si), .bs_so(bs_so)
    );

    // Model of an 8-cell external chain with its update latch.
    localparam logic [7:0] PINS = 8'hA5;
    logic [7:0] ch_sr = 8'h00, ch_latch = 8'h00;
    int cap_n = 0, sh_n = 0, upd_n = 0;
    always @(posedge tck) begin
        if (bs_capture) begin ch_sr <= PINS; cap_n <= cap_n + 1; end
        else if (bs_shift) begin ch_sr <= {bs_si, ch_sr[7:1]}; sh_n <= sh_n + 1; end
        if (bs_update) begin ch_latch <= ch_sr; upd_n <= upd_n + 1; end
    end
    assign bs_so = ch_sr[0];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One tck period: read tdo after the falling edge, then drive inputs.
    task automatic step(input logic tms_v, input logic tdi_v, output logic tdo_v);
        @(negedge tck); #2;
        tdo_v = tdo;
        last_oe = tdo_oe;
        tms = tms_v;
        tdi = tdi_v;
    endtask

    task automatic idle();
        logic b;
        step(1'b0, 1'b0, b);
    endtask

    // Load an instruction from Run-Test/Idle; checks capture pattern (R3).
    task automatic ir_load(input logic [3:0] op);
        logic b; logic [3:0] got; bit oe_ok = 1;
        step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i], b);
            got[i] = b;
            if (!last_oe) oe_ok = 0;
        end
        step(1, 0, b); step(0, 0, b); idle();
        chk(got == 4'b0001, "R3 capture pattern", {60'd0, got}, 64'd1);
        chk(oe_ok, "R10 oe during Shift-IR", {63'd0, oe_ok}, 64'd1);
    endtask

    // Data scan of n bits from Run-Test/Idle back to Run-Test/Idle.
    task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic b; bit oe_ok = 1;
        dout = '0;
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], b);
            dout[i] = b;
            if (!last_oe) oe_ok = 0;
            if (i == 0) begin
                @(posedge tck); #1;
                chk(tdo == b, "R10 tdo holds over rising edge", {63'd0, tdo}, {63'd0, b});
            end
        end
        step(1, 0, b); step(0, 0, b); idle();
        chk(oe_ok, "R10 oe during Shift-DR", {63'd0, oe_ok}, 64'd1);
        chk(tdo_oe == 1'b0, "R10 oe low in idle", {63'd0, tdo_oe}, 64'd0);
    endtask

    localparam logic [63:0] ID_EXP = 64'h0940_303F;

    task automatic t_reset();
        logic [63:0] d;
        trst_n = 0; tms = 1;
        repeat (3) @(posedge tck);
        @(negedge tck); #2;
        chk(tdo_oe == 0, "R1 oe after reset", {63'd0, tdo_oe}, 64'd0);
        chk(core_rst_req == 0, "R1 core reset after reset", {63'd0, core_rst_req}, 64'd0);
        chk(bs_drive_pins == 0, "R1 drive after reset", {63'd0, bs_drive_pins}, 64'd0);
        trst_n = 1;
        idle(); idle();
        dr_scan(32, 64'h0, d);
        chk(d == ID_EXP, "R1 R4 default IDCODE scan", d, ID_EXP);
    endtask

    task automatic t_bypass();
        logic [63:0] d; logic [7:0] pat = 8'b1011_0010;
        ir_load(4'hF);
        dr_scan(8, {56'd0, pat}, d);
        chk(d[7:0] == {pat[6:0], 1'b0}, "R5 bypass delay", d, {56'd0, pat[6:0], 1'b0});
    endtask

    task automatic t_unused();
        logic [63:0] d;
        for (int k = 0; k < 3; k++) begin
            logic [3:0] op = (k == 0) ? 4'h5 : (k == 1) ? 4'h9 : 4'hE;
            ir_load(op);
            dr_scan(4, 64'hB, d);
            chk(d[3:0] == 4'b0110, "R6 unused opcode acts as bypass", d, 64'h6);
            chk(bs_sel == 0, "R6 chain not selected", {63'd0, bs_sel}, 64'd0);
        end
    endtask

    task automatic t_five_high();
        logic b; logic [63:0] d;
        ir_load(4'hF);
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 5; i++) step(1, 1, b);
        idle(); idle();
        dr_scan(32, 64'h0, d);
        chk(d == ID_EXP, "R2 five-high escape restores IDCODE", d, ID_EXP);
    endtask

    task automatic t_core_reset();
        logic [63:0] d;
        ir_load(4'hC);
        chk(core_rst_req == 0, "R7 idle before shift", {63'd0, core_rst_req}, 64'd0);
        dr_scan(1, 64'h1, d);
        chk(d[0] == 0, "R7 no capture, old content out", d, 64'd0);
        chk(core_rst_req == 1, "R7 request asserted", {63'd0, core_rst_req}, 64'd1);
        ir_load(4'hF);
        chk(core_rst_req == 1, "R7 held across instruction change", {63'd0, core_rst_req}, 64'd1);
        dr_scan(4, 64'h5, d);
        chk(d[3:0] == 4'hA, "R7 controller still working", d, 64'hA);
        ir_load(4'hC);
        dr_scan(1, 64'h0, d);
        chk(d[0] == 1, "R7 one shifted back out", d, 64'd1);
        chk(core_rst_req == 0, "R7 request released", {63'd0, core_rst_req}, 64'd0);
    endtask

    task automatic t_sample();
        logic [63:0] d; int c0, s0, u0;
        ir_load(4'h2);
        chk(bs_drive_pins == 0, "R9 sample leaves pins alone", {63'd0, bs_drive_pins}, 64'd0);
        chk(bs_sel == 1, "R8 chain selected", {63'd0, bs_sel}, 64'd1);
        c0 = cap_n; s0 = sh_n; u0 = upd_n;
        dr_scan(8, 64'h3C, d);
        chk(d[7:0] == PINS, "R8 captured pins out", d, {56'd0, PINS});
        chk(ch_latch == 8'h3C, "R8 chain latch updated", {56'd0, ch_latch}, 64'h3C);
        chk(cap_n - c0 == 1 && sh_n - s0 == 8 && upd_n - u0 == 1, "R8 strobe counts",
            64'(sh_n - s0), 64'd8);
    endtask

    task automatic t_extest();
        logic [63:0] d;
        ir_load(4'h0);
        chk(bs_drive_pins == 1, "R9 extest drives pins", {63'd0, bs_drive_pins}, 64'd1);
        dr_scan(8, 64'h96, d);
        chk(d[7:0] == PINS, "R8 extest capture", d, {56'd0, PINS});
        chk(ch_latch == 8'h96, "R8 extest update", {56'd0, ch_latch}, 64'h96);
        ir_load(4'h1);
        chk(bs_drive_pins == 0, "R9 drive off after IDCODE", {63'd0, bs_drive_pins}, 64'd0);
        dr_scan(32, 64'h0, d);
        chk(d == ID_EXP, "R4 IDCODE by opcode", d, ID_EXP);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_unused();
        t_five_high();
        t_core_reset();
        t_sample();
        t_extest();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge tck);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule